// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a memory effective address from four pieces: a 32-bit signed displacement, a 64-bit base register value, a 64-bit index register value and a 2-bit scale code. The index is multiplied by 1, 2, 4 or 8, and the three terms are added with wrap-around at 2^64. Either the base or the index can be marked absent, in which case it adds nothing. The result appears on a registered output one cycle after the request.

In address mode the unit also checks the 48-bit address-space rule. Any address whose top 16 bits are not all zero is non-canonical, and the unit raises a fault flag for it. The same datapath serves an address-as-data mode that hands the sum back as an ordinary value. That mode never raises the fault flag, so an arithmetic use of the adder cannot disturb any status.

Top module: `ea_scaled_gen`

## Requirements
- R1: For each accepted request, `out_result` equals the sign-extended displacement plus the base term plus the scaled index term, modulo 2^64.
- R2: The scale code `in_scale` multiplies the index as follows: 2'b00 by 1, 2'b01 by 2, 2'b10 by 4 and 2'b11 by 8. Bits shifted past bit 63 are lost.
- R3: `in_disp` is a two's-complement value; bit 31 is copied into bits 63..32 before the addition.
- R4: When `in_base_en` is 0 the base term is zero whatever `in_base` holds. When `in_index_en` is 0 the index term is zero whatever `in_index` and `in_scale` hold.
- R5: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high.
- R6: In address mode (`in_mode_lea` = 0), `out_fault` is 1 exactly when bits 63..48 of the result are not all zero.
- R7: In address-as-data mode (`in_mode_lea` = 1), `out_fault` is 0 for every result, and `out_lea` repeats the mode of the request.
- R8: While `rst_n` is low, `out_valid`, `out_result`, `out_lea` and `out_fault` are all 0.
- R9: A cycle with `in_valid` low leaves `out_result`, `out_lea` and `out_fault` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_mode_lea | input | 1 | 1 = address-as-data mode, 0 = address mode |
| in_disp | input | 32 | Signed displacement |
| in_base | input | 64 | Base register value |
| in_base_en | input | 1 | Base term present |
| in_index | input | 64 | Index register value |
| in_index_en | input | 1 | Index term present |
| in_scale | input | 2 | Index scale code (shift 0 to 3) |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_result | output | 64 | Computed address or value |
| out_lea | output | 1 | Mode of the result being presented |
| out_fault | output | 1 | Non-canonical address in address mode |

## Verification
On every cycle the assertions check the one-cycle valid timing and the hold of the outputs on idle cycles. They also check that the address-as-data mode never faults, that the fault flag matches the upper-16-bit rule, and that a request with no base and no index yields the sign-extended displacement. Only the bench scenarios can show that the arithmetic itself is right. Those scenarios cover every scale code, displacements that are negative or at the sign boundary, absent operands that carry junk, wrap-around past 2^64, and results at 2^48 - 1 and at 2^48. The reference model checks each of these against an independent multiply-and-add on every clock.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    SC_X1 = 2'b00,
    SC_X2 = 2'b01,
    SC_X4 = 2'b10,
    SC_X8 = 2'b11
  } ea_scale_e;

  localparam int unsigned EA_WIDTH_DEF   = 64;
  localparam int unsigned EA_DISP_DEF    = 32;
  localparam int unsigned EA_VA_BITS_DEF = 48;
endpackage

// File: rtl/ea_sext.sv
module ea_sext #(
  parameter int unsigned IN_W  = 32,
  parameter int unsigned OUT_W = 64
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  localparam int unsigned EXT_W = OUT_W - IN_W;

  function automatic logic [OUT_W-1:0] widen_signed(input logic [IN_W-1:0] v);
    return {{EXT_W{v[IN_W-1]}}, v};
  endfunction

  assign val_o = widen_signed(val_i);
endmodule

// File: rtl/ea_term_gate.sv
module ea_term_gate #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] base_i,
  input  logic         base_en_i,
  input  logic [W-1:0] index_i,
  input  logic         index_en_i,
  input  logic [1:0]   scale_i,
  output logic [W-1:0] base_term_o,
  output logic [W-1:0] index_term_o
);
  import ea_pkg::*;

  localparam int unsigned NOPS = 2;

  logic [W-1:0] raw_v   [NOPS];
  logic         en_v    [NOPS];
  logic [W-1:0] gated_v [NOPS];

  assign raw_v[0] = base_i;
  assign en_v[0]  = base_en_i;
  assign raw_v[1] = index_i;
  assign en_v[1]  = index_en_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_gate
    assign gated_v[g] = en_v[g] ? raw_v[g] : '0;
  end

  function automatic logic [W-1:0] scale_by_code(input logic [W-1:0] v,
                                                  input ea_scale_e sc);
    logic [W-1:0] r;
    case (sc)
      SC_X1:   r = v;
      SC_X2:   r = {v[W-2:0], 1'b0};
      SC_X4:   r = {v[W-3:0], 2'b00};
      default: r = {v[W-4:0], 3'b000};
    endcase
    return r;
  endfunction

  assign base_term_o  = gated_v[0];
  assign index_term_o = scale_by_code(gated_v[1], ea_scale_e'(scale_i));
endmodule

// File: rtl/ea_sum3.sv
module ea_sum3 #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] part_sum;
  logic [W-1:0] part_cy;

  for (genvar i = 0; i < W; i++) begin : g_csa
    assign part_sum[i] = a_i[i] ^ b_i[i] ^ c_i[i];
    assign part_cy[i]  = (a_i[i] & b_i[i]) | (a_i[i] & c_i[i]) | (b_i[i] & c_i[i]);
  end

  function automatic logic [W-1:0] merge_rows(input logic [W-1:0] s,
                                               input logic [W-1:0] c);
    return s + {c[W-2:0], 1'b0};
  endfunction

  assign sum_o = merge_rows(part_sum, part_cy);
endmodule

// File: rtl/ea_canon_chk.sv
module ea_canon_chk #(
  parameter int unsigned W       = 64,
  parameter int unsigned VA_BITS = 48
) (
  input  logic [W-1:0] addr_i,
  output logic         noncanon_o
);
  localparam int unsigned HI_W = W - VA_BITS;

  logic [HI_W-1:0] high_part;
  assign high_part  = addr_i[W-1:VA_BITS];
  assign noncanon_o = |high_part;
endmodule

// File: rtl/ea_scaled_gen.sv
module ea_scaled_gen #(
  parameter int unsigned W       = ea_pkg::EA_WIDTH_DEF,
  parameter int unsigned DISP_W  = ea_pkg::EA_DISP_DEF,
  parameter int unsigned VA_BITS = ea_pkg::EA_VA_BITS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_mode_lea,
  input  logic [DISP_W-1:0] in_disp,
  input  logic [W-1:0]      in_base,
  input  logic              in_base_en,
  input  logic [W-1:0]      in_index,
  input  logic              in_index_en,
  input  logic [1:0]        in_scale,
  output logic              out_valid,
  output logic [W-1:0]      out_result,
  output logic              out_lea,
  output logic              out_fault
);
  logic [W-1:0] disp_wide;
  logic [W-1:0] base_term;
  logic [W-1:0] index_term;
  logic [W-1:0] sum_w;
  logic         noncanon_w;
  logic         fault_w;

  ea_sext #(.IN_W(DISP_W), .OUT_W(W)) u_sext (
    .val_i (in_disp),
    .val_o (disp_wide)
  );

  ea_term_gate #(.W(W)) u_gate (
    .base_i       (in_base),
    .base_en_i    (in_base_en),
    .index_i      (in_index),
    .index_en_i   (in_index_en),
    .scale_i      (in_scale),
    .base_term_o  (base_term),
    .index_term_o (index_term)
  );

  ea_sum3 #(.W(W)) u_sum (
    .a_i   (disp_wide),
    .b_i   (base_term),
    .c_i   (index_term),
    .sum_o (sum_w)
  );

  ea_canon_chk #(.W(W), .VA_BITS(VA_BITS)) u_canon (
    .addr_i     (sum_w),
    .noncanon_o (noncanon_w)
  );

  assign fault_w = noncanon_w & ~in_mode_lea;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_lea    <= 1'b0;
      out_fault  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= sum_w;
        out_lea    <= in_mode_lea;
        out_fault  <= fault_w;
      end
    end
  end
endmodule

// File: rtl/ea_scaled_gen_chk.sv
module ea_scaled_gen_chk #(
  parameter int unsigned W       = 64,
  parameter int unsigned DISP_W  = 32,
  parameter int unsigned VA_BITS = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_mode_lea,
  input logic [DISP_W-1:0] in_disp,
  input logic              in_base_en,
  input logic              in_index_en,
  input logic              noncanon_w,
  input logic              out_valid,
  input logic [W-1:0]      out_result,
  input logic              out_lea,
  input logic              out_fault
);
  localparam int unsigned EXT_W = W - DISP_W;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R5
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R5
  AST_LEA_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_lea) |-> !out_fault); // R7
  AST_MODE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_lea == $past(in_mode_lea))); // R7
  AST_FAULT_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_lea) |-> (out_fault == (out_result[W-1:VA_BITS] != '0))); // R6
  AST_FAULT_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_mode_lea && noncanon_w) |=> out_fault); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_fault) && $stable(out_lea))); // R9
  AST_DISP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_base_en && !in_index_en) |=>
      (out_result == {{EXT_W{$past(in_disp[DISP_W-1])}}, $past(in_disp)})); // R4
endmodule

bind ea_scaled_gen ea_scaled_gen_chk #(
  .W(W), .DISP_W(DISP_W), .VA_BITS(VA_BITS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_mode_lea (in_mode_lea),
  .in_disp     (in_disp),
  .in_base_en  (in_base_en),
  .in_index_en (in_index_en),
  .noncanon_w  (noncanon_w),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_lea     (out_lea),
  .out_fault   (out_fault)
);

// File: tb/tb_ea_scaled_gen.sv
`timescale 1ns/1ps
module tb_ea_scaled_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_mode_lea = 1'b0;
  logic [31:0] in_disp = '0;
  logic [63:0] in_base = '0;
  logic        in_base_en = 1'b0;
  logic [63:0] in_index = '0;
  logic        in_index_en = 1'b0;
  logic [1:0]  in_scale = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_lea;
  logic        out_fault;

  int n_checks = 0;
  int n_fail   = 0;

  // expected outputs after the next rising edge / currently presented
  logic        exp_valid = 1'b0, cur_valid = 1'b0;
  logic [63:0] exp_res = '0, cur_res = '0;
  logic        exp_lea = 1'b0, cur_lea = 1'b0;
  logic        exp_fault = 1'b0, cur_fault = 1'b0;
  string       exp_tag = "R1", cur_tag = "R1";

  always #2.5 clk = ~clk;

  ea_scaled_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode_lea(in_mode_lea),
    .in_disp(in_disp), .in_base(in_base), .in_base_en(in_base_en),
    .in_index(in_index), .in_index_en(in_index_en), .in_scale(in_scale),
    .out_valid(out_valid), .out_result(out_result), .out_lea(out_lea),
    .out_fault(out_fault)
  );

  task automatic check64(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // independent model: multiply instead of shift, signed cast for extension
  function automatic logic [63:0] model_ea(logic [31:0] d, logic [63:0] b, logic be,
                                           logic [63:0] x, logic xe, logic [1:0] sc);
    longint signed dd;
    logic [63:0] acc;
    logic [63:0] mult;
    dd   = longint'($signed(d));
    mult = 64'd1;
    for (int k = 0; k < int'(sc); k++) mult = mult * 64'd2;
    acc  = 64'(dd);
    if (be) acc = acc + b;
    if (xe) acc = acc + x * mult;
    return acc;
  endfunction

  task automatic compare_now();
    check64("R5", "valid", {63'd0, out_valid}, {63'd0, cur_valid});
    check64(cur_tag, "result", out_result, cur_res);
    check64(cur_lea ? "R7" : "R6", "fault", {63'd0, out_fault}, {63'd0, cur_fault});
    check64("R7", "mode echo", {63'd0, out_lea}, {63'd0, cur_lea});
  endtask

  // one clock: check what the design shows, drive a new request, model it
  task automatic step(string tag, logic v, logic lea, logic [31:0] d, logic [63:0] b,
                      logic be, logic [63:0] x, logic xe, logic [1:0] sc);
    @(negedge clk);
    cur_valid = exp_valid; cur_res = exp_res; cur_lea = exp_lea;
    cur_fault = exp_fault; cur_tag = exp_tag;
    compare_now();
    in_valid = v; in_mode_lea = lea; in_disp = d; in_base = b; in_base_en = be;
    in_index = x; in_index_en = xe; in_scale = sc;
    exp_valid = v;
    exp_tag   = tag;
    if (v) begin
      exp_res   = model_ea(d, b, be, x, xe, sc);
      exp_lea   = lea;
      exp_fault = !lea && (exp_res >= 64'h0001_0000_0000_0000);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check64("R8", "reset valid",  {63'd0, out_valid}, 64'd0);
    check64("R8", "reset result", out_result, 64'd0);
    check64("R8", "reset fault",  {63'd0, out_fault}, 64'd0);
    check64("R8", "reset lea",    {63'd0, out_lea}, 64'd0);
    rst_n = 1'b1;

    // R2: each scale code on a present index
    for (int s = 0; s < 4; s++)
      step("R2", 1, 0, 32'd0, 64'd0, 0, 64'h10, 1, 2'(s));
    step("R2", 1, 0, 32'd0, 64'd0, 0, 64'hF000_0000_0000_0001, 1, 2'b11);
    // R3: sign extension of the displacement
    step("R3", 1, 0, 32'hFFFF_FFFF, 64'h1000, 1, 64'd0, 0, 2'b00);
    step("R3", 1, 0, 32'h8000_0000, 64'd0, 0, 64'd0, 0, 2'b00);
    step("R3", 1, 1, 32'h7FFF_FFFF, 64'd1, 1, 64'd0, 0, 2'b00);
    // R4: absent operands carry junk that must not count
    step("R4", 1, 0, 32'd4, 64'hDEAD_BEEF_1234_5678, 0, 64'h20, 1, 2'b10);
    step("R4", 1, 0, 32'd4, 64'h3000, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2'b11);
    step("R4", 1, 1, 32'h10, 64'hFFFF_0000_0000_0000, 0, 64'hAAAA_0000_0000_0000, 0, 2'b01);
    // R1: full sum and wrap past 2^64
    step("R1", 1, 0, 32'd8, 64'h7000_0000, 1, 64'd5, 1, 2'b10);
    step("R1", 1, 0, 32'd1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 64'd0, 0, 2'b00);
    step("R1", 1, 0, 32'hFFFF_FFF0, 64'd0, 1, 64'd1, 1, 2'b11);
    // R6: 48-bit boundary
    step("R6", 1, 0, 32'd0, 64'h0000_FFFF_FFFF_FFFF, 1, 64'd0, 0, 2'b00);
    step("R6", 1, 0, 32'd1, 64'h0000_FFFF_FFFF_FFFF, 1, 64'd0, 0, 2'b00);
    step("R6", 1, 0, 32'd0, 64'h0000_8000_0000_0000, 1, 64'h0000_8000_0000_0000, 1, 2'b00);
    // R7: same out-of-range sums in address-as-data mode never fault
    step("R7", 1, 1, 32'd1, 64'h0000_FFFF_FFFF_FFFF, 1, 64'd0, 0, 2'b00);
    step("R7", 1, 1, 32'h8000_0000, 64'd0, 0, 64'd0, 0, 2'b00);
    // R9: idle cycles after a faulting request hold everything
    step("R9", 1, 0, 32'd0, 64'h1234_0000_0000_0000, 1, 64'd0, 0, 2'b00);
    step("R9", 0, 1, 32'h55, 64'd7, 1, 64'd9, 1, 2'b01);
    step("R9", 0, 0, 32'h66, 64'd0, 0, 64'd0, 0, 2'b00);
    step("R9", 0, 1, 32'h77, 64'd1, 1, 64'd1, 1, 2'b11);
    // R1: mixed random traffic with random idle gaps
    for (int i = 0; i < 400; i++)
      step("R1", ($urandom_range(0, 3) != 0), 1'($urandom), $urandom,
           {$urandom, $urandom} >> $urandom_range(0, 20), 1'($urandom),
           {$urandom, $urandom} >> $urandom_range(0, 20), 1'($urandom),
           2'($urandom));
    step("R5", 0, 0, 32'd0, 64'd0, 0, 64'd0, 0, 2'b00);
    step("R5", 0, 0, 32'd0, 64'd0, 0, 64'd0, 0, 2'b00);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule